// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block takes eight interrupt request lines and decides which one the processor should serve. It keeps three 8-bit registers: pending requests, levels currently in service and a mask. It raises a single interrupt output when an unmasked request outranks every level in service. Line 0 has the highest priority and line 7 the lowest. The processor answers with two acknowledge pulses. The first pulse moves the winning request into service. The second pulse returns an 8-bit vector, which is a programmed base plus the line number.

Software reaches the block through a byte-wide port with two addresses. A write to the even address with bit 4 set starts a configuration sequence, and the bytes after it go to the odd address. That sequence sets the trigger style, the vector base, the cascade byte and the end-of-interrupt style. Once configuration is done, odd-address writes load the mask, and even-address writes are commands. A command can retire one in-service level or choose which register an even-address read returns. A request that vanishes before it is acknowledged still completes the handshake, but with the lowest line's vector and no in-service bit set.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the block is unconfigured: int_o is 0, the mask reads 0xFF at the odd address, the even address reads the request register, and acknowledge pulses are ignored.
- R2: An even-address write with bit 4 set starts configuration. That byte's bit 3 selects level triggering, bit 1 selects single (no cascade byte) and bit 0 requests a mode byte. The odd-address bytes that follow are, in order: the vector base; the cascade byte, only when bit 1 was 0; the mode byte, only when bit 0 was 1. Starting configuration clears the mask, the in-service register and the read selection.
- R3: Once configured, an odd-address write loads the mask and an odd-address read returns it; a mask bit of 1 blocks that line from raising int_o.
- R4: int_o is 1 only when the block is configured, no acknowledge is half done, and the lowest-numbered unmasked pending line is lower than every line in service.
- R5: The first acknowledge pulse sets the winner's in-service bit and clears its request bit. The second pulse makes vec_valid_o high for exactly one cycle, with vec_o equal to base plus line number.
- R6: An even-address command whose bits 7:5 are 011 and whose bits 4:3 are 00 clears the in-service bit of the line given in bits 2:0. Other codes with bits 4:3 equal to 00 change nothing.
- R7: An even-address command with bits 4:3 equal to 01 and bit 1 set selects the register for later even-address reads: bit 0 equal to 0 selects the request register, and 1 selects the in-service register.
- R8: If no unmasked request outranks the in-service levels at the first pulse, the handshake still finishes with vector base+7 and the in-service register is left unchanged. This holds even when line 7 is masked.
- R9: When mode byte bit 1 is set (automatic end-of-interrupt), the in-service bit set by the first pulse is cleared at the second pulse.
- R10: In edge mode a request bit is set by a rising input edge, held while the input stays high, and cleared when the input drops or when the request is acknowledged. In level mode the request register follows the inputs.
- R11: cascade_o holds the last cascade byte written during configuration and reads 0 after a configuration that skips that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | One-cycle write strobe |
| addr_i | input | 1 | Register address select (0 even, 1 odd) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_i | input | 8 | Interrupt request lines |
| int_o | output | 1 | Interrupt to the processor |
| inta_i | input | 1 | One-cycle acknowledge pulse |
| vec_o | output | 8 | Vector delivered on the second acknowledge |
| vec_valid_o | output | 1 | vec_o is valid this cycle |
| cascade_o | output | 8 | Captured cascade configuration byte |

## Verification
Each register write, input change and acknowledge pulse is sampled on one rising edge. Its effect is visible after that same edge: request and in-service contents, the mask, the read selection, int_o and the vector pulse all change exactly one edge after the stimulus. The bench drives on falling edges and checks on the next falling edge, so every check lands in the first cycle where the new value is due. Expected vectors are queued by the acknowledge task before the second pulse. A monitor removes one entry from the queue for each cycle in which vec_valid_o is high, which also catches extra or missing vector pulses.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    CFG_UNINIT,
    CFG_WAIT_BASE,
    CFG_WAIT_CASC,
    CFG_WAIT_MODE,
    CFG_READY
  } cfg_state_e;

  typedef enum logic {
    ACK_IDLE,
    ACK_WAIT_VEC
  } ack_state_e;

  localparam int unsigned INIT_BIT  = 4;
  localparam int unsigned CMD3_BIT  = 3;
  localparam logic [2:0]  EOI_SPEC  = 3'b011;
endpackage

// File: rtl/pic_ffs.sv
module pic_ffs #(
  parameter int unsigned W  = 8,
  localparam int unsigned LW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          valid_o,
  output logic [LW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        valid_o = 1'b1;
        idx_o   = LW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_irr.sv
module pic_irr #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         level_mode_i,
  input  logic [W-1:0] irq_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] irr_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] irr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq_i;
      if (level_mode_i) irr_q <= irq_i;
      else              irr_q <= irq_i & (irr_q | ~prev_q) & ~clr_i;
    end
  end

  assign irr_o = irr_q;

  AST_IRR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_mode_i) |=> ((irr_q & ~$past(irq_i)) == '0)); // R10
endmodule

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LW    = $clog2(W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              init_o,
  output logic              eoi_o,
  output logic [LW-1:0]     eoi_lvl_o,
  output logic [W-1:0]      mask_o,
  output logic [DATA_W-1:0] base_o,
  output logic [DATA_W-1:0] cascade_o,
  output logic              level_mode_o,
  output logic              aeoi_o,
  output logic              rd_isr_o
);
  cfg_state_e        st_q;
  logic [W-1:0]      mask_q;
  logic [DATA_W-1:0] base_q, casc_q;
  logic              ltim_q, single_q, need_mode_q, aeoi_q, rd_isr_q;
  logic              wr_even;

  assign wr_even   = wr_i & ~addr_i;
  assign init_o    = wr_even & wdata_i[INIT_BIT];
  assign ready_o   = (st_q == CFG_READY);
  assign eoi_o     = wr_even & ready_o & ~wdata_i[INIT_BIT] & ~wdata_i[CMD3_BIT]
                   & (wdata_i[7:5] == EOI_SPEC);
  assign eoi_lvl_o = wdata_i[LW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= CFG_UNINIT;
      mask_q      <= '1;
      base_q      <= '0;
      casc_q      <= '0;
      ltim_q      <= 1'b0;
      single_q    <= 1'b0;
      need_mode_q <= 1'b0;
      aeoi_q      <= 1'b0;
      rd_isr_q    <= 1'b0;
    end else if (init_o) begin
      st_q        <= CFG_WAIT_BASE;
      mask_q      <= '0;
      casc_q      <= '0;
      aeoi_q      <= 1'b0;
      rd_isr_q    <= 1'b0;
      ltim_q      <= wdata_i[3];
      single_q    <= wdata_i[1];
      need_mode_q <= wdata_i[0];
    end else if (wr_i) begin
      unique case (st_q)
        CFG_WAIT_BASE: if (addr_i) begin
          base_q <= wdata_i;
          if (!single_q)        st_q <= CFG_WAIT_CASC;
          else if (need_mode_q) st_q <= CFG_WAIT_MODE;
          else                  st_q <= CFG_READY;
        end
        CFG_WAIT_CASC: if (addr_i) begin
          casc_q <= wdata_i;
          st_q   <= need_mode_q ? CFG_WAIT_MODE : CFG_READY;
        end
        CFG_WAIT_MODE: if (addr_i) begin
          aeoi_q <= wdata_i[1];
          st_q   <= CFG_READY;
        end
        CFG_READY: begin
          if (addr_i) mask_q <= wdata_i[W-1:0];
          else if (wdata_i[CMD3_BIT] && wdata_i[1]) rd_isr_q <= wdata_i[0];
        end
        default: ;
      endcase
    end
  end

  assign mask_o       = mask_q;
  assign base_o       = base_q;
  assign cascade_o    = casc_q;
  assign level_mode_o = ltim_q;
  assign aeoi_o       = aeoi_q;
  assign rd_isr_o     = rd_isr_q;

  AST_INIT_UNMASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |=> (mask_q == '0 && !rd_isr_q && !ready_o)); // R2
endmodule

// File: rtl/pic_ack.sv
module pic_ack
  import pic_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LW    = $clog2(W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inta_i,
  input  logic              ready_i,
  input  logic              init_i,
  input  logic              pend_i,
  input  logic [LW-1:0]     pend_lvl_i,
  input  logic              eoi_i,
  input  logic [LW-1:0]     eoi_lvl_i,
  input  logic              aeoi_i,
  input  logic [DATA_W-1:0] base_i,
  output logic [W-1:0]      isr_o,
  output logic [W-1:0]      irr_clr_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] vec_o,
  output logic              vec_valid_o
);
  ack_state_e        st_q;
  logic [LW-1:0]     lvl_q;
  logic              spur_q;
  logic [W-1:0]      isr_q, isr_n;
  logic [DATA_W-1:0] vec_q;
  logic              vec_valid_q;
  logic              ack1, ack2;

  assign ack1      = inta_i & ready_i & (st_q == ACK_IDLE);
  assign ack2      = inta_i & (st_q == ACK_WAIT_VEC);
  assign irr_clr_o = (ack1 && pend_i) ? (W'(1) << pend_lvl_i) : '0;
  assign busy_o    = (st_q == ACK_WAIT_VEC);

  always_comb begin
    isr_n = isr_q;
    if (ack1 && pend_i) isr_n[pend_lvl_i] = 1'b1;
    if (ack2 && aeoi_i && !spur_q) isr_n[lvl_q] = 1'b0;
    if (eoi_i) isr_n[eoi_lvl_i] = 1'b0;
    if (init_i) isr_n = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ACK_IDLE;
      lvl_q       <= '0;
      spur_q      <= 1'b0;
      isr_q       <= '0;
      vec_q       <= '0;
      vec_valid_q <= 1'b0;
    end else begin
      isr_q       <= isr_n;
      vec_valid_q <= ack2;
      if (ack2) vec_q <= base_i + DATA_W'(lvl_q);
      if (init_i) begin
        st_q <= ACK_IDLE;
      end else if (ack1) begin
        st_q   <= ACK_WAIT_VEC;
        spur_q <= ~pend_i;
        lvl_q  <= pend_i ? pend_lvl_i : LW'(W - 1);  // lost request: lowest line
      end else if (ack2) begin
        st_q <= ACK_IDLE;
      end
    end
  end

  assign isr_o       = isr_q;
  assign vec_o       = vec_q;
  assign vec_valid_o = vec_valid_q;

  AST_EOI_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_i |=> !isr_q[$past(eoi_lvl_i)]); // R6
  AST_SPUR_KEEPS_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && ready_i && st_q == ACK_IDLE && !pend_i && !eoi_i && !init_i) |=> $stable(isr_q)); // R8
  AST_AEOI_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && busy_o && aeoi_i && !spur_q) |=> !isr_q[$past(lvl_q)]); // R9
  AST_VEC_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> !vec_valid_o); // R5
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned LW     = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic               int_o,
  input  logic               inta_i,
  output logic [DATA_W-1:0]  vec_o,
  output logic               vec_valid_o,
  output logic [DATA_W-1:0]  cascade_o
);
  logic               ready, init, eoi, level_mode, aeoi, rd_isr, busy;
  logic [LW-1:0]      eoi_lvl, req_lvl, isr_lvl;
  logic [NUM_IRQ-1:0] mask, irr, isr, irr_clr, req_vec;
  logic [DATA_W-1:0]  base;
  logic               req_valid, isr_valid, pend;

  pic_cfg #(.W(NUM_IRQ), .DATA_W(DATA_W)) u_cfg (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .ready_o(ready), .init_o(init), .eoi_o(eoi), .eoi_lvl_o(eoi_lvl),
    .mask_o(mask), .base_o(base), .cascade_o(cascade_o),
    .level_mode_o(level_mode), .aeoi_o(aeoi), .rd_isr_o(rd_isr)
  );

  pic_irr #(.W(NUM_IRQ)) u_irr (
    .clk_i, .rst_ni, .level_mode_i(level_mode), .irq_i,
    .clr_i(irr_clr), .irr_o(irr)
  );

  assign req_vec = irr & ~mask;

  pic_ffs #(.W(NUM_IRQ)) u_ffs_req (.vec_i(req_vec), .valid_o(req_valid), .idx_o(req_lvl));
  pic_ffs #(.W(NUM_IRQ)) u_ffs_isr (.vec_i(isr),     .valid_o(isr_valid), .idx_o(isr_lvl));

  assign pend = req_valid & (~isr_valid | (req_lvl < isr_lvl));

  pic_ack #(.W(NUM_IRQ), .DATA_W(DATA_W)) u_ack (
    .clk_i, .rst_ni, .inta_i, .ready_i(ready), .init_i(init),
    .pend_i(pend), .pend_lvl_i(req_lvl), .eoi_i(eoi), .eoi_lvl_i(eoi_lvl),
    .aeoi_i(aeoi), .base_i(base), .isr_o(isr), .irr_clr_o(irr_clr),
    .busy_o(busy), .vec_o, .vec_valid_o
  );

  assign int_o   = ready & pend & ~busy;
  assign rdata_o = addr_i ? DATA_W'(mask) : (rd_isr ? DATA_W'(isr) : DATA_W'(irr));

  AST_INT_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (|(irr & ~mask))); // R4
  AST_INT_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ready); // R1
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, addr_i = 1'b0, inta_i = 1'b0;
  logic [7:0] wdata_i = '0, irq_i = '0;
  logic [7:0] rdata_o, vec_o, cascade_o;
  logic       int_o, vec_valid_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #5 clk_i = ~clk_i;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .rdata_o, .irq_i,
    .int_o, .inta_i, .vec_o, .vec_valid_o, .cascade_o
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk_i); wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; #1 d = rdata_o;
  endtask

  task automatic set_irq(logic [7:0] v);
    @(negedge clk_i); irq_i = v;
    @(negedge clk_i);
  endtask

  task automatic pulse();
    @(negedge clk_i); inta_i = 1'b1;
    @(negedge clk_i); inta_i = 1'b0;
  endtask

  task automatic ack_vec(logic [7:0] exp);
    exp_q.push_back(exp);
    pulse();
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && vec_valid_o) begin
      if (exp_q.size() == 0) chk("R5 unexpected vector", vec_o, 8'hxx);
      else chk("R5 vector", vec_o, exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 int_o", {7'b0, int_o}, 8'h00);
    rd(1'b1, d); chk("R1 mask", d, 8'hFF);
    rd(1'b0, d); chk("R1 irr", d, 8'h00);
    pulse(); pulse();   // ignored while unconfigured: no vector expected

    // R2 / R11 full sequence
    wr(1'b0, 8'h11); wr(1'b1, 8'h30); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd(1'b1, d); chk("R2 mask cleared", d, 8'h00);
    chk("R11 cascade", cascade_o, 8'h04);

    // R3 mask
    wr(1'b1, 8'hA5); rd(1'b1, d); chk("R3 mask read", d, 8'hA5);
    set_irq(8'h01); chk("R3 masked line no int", {7'b0, int_o}, 8'h00);
    set_irq(8'h00); wr(1'b1, 8'h00);

    // R10 edge + R4 + R5
    set_irq(8'h08);
    chk("R4 int raised", {7'b0, int_o}, 8'h01);
    rd(1'b0, d); chk("R10 edge irr", d, 8'h08);
    pulse();
    rd(1'b0, d); chk("R5 irr cleared by ack", d, 8'h00);
    wr(1'b0, 8'h0B); rd(1'b0, d); chk("R7 isr select", d, 8'h08);
    chk("R5 int drops", {7'b0, int_o}, 8'h00);
    ack_vec(8'h33);

    // R4 nesting
    set_irq(8'h28); chk("R4 lower blocked", {7'b0, int_o}, 8'h00);
    set_irq(8'h2A); chk("R4 higher passes", {7'b0, int_o}, 8'h01);
    pulse(); ack_vec(8'h31);
    rd(1'b0, d); chk("R5 isr nested", d, 8'h0A);

    // R6 eoi
    wr(1'b0, 8'h20); rd(1'b0, d); chk("R6 other code ignored", d, 8'h0A);
    wr(1'b0, 8'h61); rd(1'b0, d); chk("R6 eoi 1", d, 8'h08);
    wr(1'b0, 8'h63); rd(1'b0, d); chk("R6 eoi 3", d, 8'h00);
    chk("R4 pending line 5", {7'b0, int_o}, 8'h01);
    pulse(); ack_vec(8'h35); wr(1'b0, 8'h65);

    // R7 back to irr
    set_irq(8'h00); set_irq(8'h40);
    wr(1'b0, 8'h0A); rd(1'b0, d); chk("R7 irr select", d, 8'h40);
    set_irq(8'h00); rd(1'b0, d); chk("R10 edge drop", d, 8'h00);

    // R8 spurious
    wr(1'b0, 8'h0B);
    set_irq(8'h10); chk("R8 int before drop", {7'b0, int_o}, 8'h01);
    set_irq(8'h00);
    pulse(); ack_vec(8'h37);
    rd(1'b0, d); chk("R8 isr untouched", d, 8'h00);
    wr(1'b1, 8'h80);
    set_irq(8'h10); set_irq(8'h00);
    pulse(); ack_vec(8'h37);
    rd(1'b0, d); chk("R8 isr untouched masked 7", d, 8'h00);
    wr(1'b1, 8'h00);

    // R2 init clears isr, R9 auto eoi
    set_irq(8'h01); pulse(); ack_vec(8'h30); set_irq(8'h00);
    wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'h04); wr(1'b1, 8'h03);
    rd(1'b0, d); chk("R2 read sel back to irr", d, 8'h00);
    wr(1'b0, 8'h0B); rd(1'b0, d); chk("R2 isr cleared", d, 8'h00);
    set_irq(8'h04); pulse();
    rd(1'b0, d); chk("R9 isr set mid ack", d, 8'h04);
    ack_vec(8'h42);
    rd(1'b0, d); chk("R9 isr auto cleared", d, 8'h00);
    set_irq(8'h00);

    // R10 level mode, R11 skipped cascade byte
    wr(1'b0, 8'h1B); wr(1'b1, 8'h50); wr(1'b1, 8'h01);
    chk("R11 cascade skipped", cascade_o, 8'h00);
    set_irq(8'h40);
    rd(1'b0, d); chk("R10 level irr", d, 8'h40);
    pulse(); ack_vec(8'h56);
    rd(1'b0, d); chk("R10 level irr kept", d, 8'h40);
    set_irq(8'h00);
    rd(1'b0, d); chk("R10 level irr follows", d, 8'h00);

    repeat (3) @(negedge clk_i);
    chk("R5 queue drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule